// File: doc/BRIEF.md
# Standard-Locked Interlaced TV Sync Generator

This block produces the horizontal and vertical timing for an interlaced composite video encoder. A one-bit standard select picks the 525-line family or the 625-line family. The chosen family alone fixes the line length: 858 pixel clocks for 525-line timing and 864 for 625-line timing. The pixel counter runs freely at that period and takes no notice of the line timing of the upstream pixel source. The block does compare the upstream line-start pulse with its own counter and raises a one-cycle flag when the two disagree.

The frame length works differently. An upstream vertical trigger ends the current frame at the end of the line in which it arrives. This allows shorter frames that break the standard but still display, such as a 525-line frame on the 864-clock line, which gives a field rate near 59.52 Hz instead of 59.94 Hz. If no trigger arrives, the block wraps by itself after the family's line cap.

A field bit toggles at every frame boundary. In the odd field the vertical sync window is moved by half a line. A new standard selection is taken only at a frame boundary or on a synchronous clear, so the line length never changes in the middle of a line.

Top module: `tv_sync_gen`

## Requirements
- R1: With standard 0 (525-line) active, `pix_o` counts 0 to H_TOTAL_525-1 (default 857) and returns to 0. The line period is exactly H_TOTAL_525 clocks, whatever `line_start_i` does.
- R2: With standard 1 (625-line) active, `pix_o` counts 0 to H_TOTAL_625-1 (default 863) and returns to 0, with the same free-running behaviour.
- R3: `line_o` advances by one at each pixel wrap. With no trigger, the frame wraps to line 0 after line V_CAP-1, where V_CAP is V_CAP_525 (525) or V_CAP_625 (625). A frame therefore lasts H_TOTAL*V_CAP clocks.
- R4: A `vtrig_i` pulse ends the frame at the end of the line in which it is sampled. The pulse may be sampled in any cycle of the frame except the frame's final cycle. A pulse sampled in the final cycle of a frame is absorbed by that boundary and does not shorten the next frame.
- R5: `hsync_o` is high exactly while `pix_o` lies in [HS_START, HS_END): [734, 798) for standard 0 and [740, 804) for standard 1.
- R6: In field 0, `vsync_o` is high on lines [VS_START, VS_END) of the active standard. In field 1 it rises at pixel H_TOTAL/2 (429 or 432) of line VS_START and falls at pixel H_TOTAL/2 of line VS_END.
- R7: `field_o` toggles at every frame boundary, whether the frame ended on a trigger or on the cap.
- R8: `mismatch_o` is high for one cycle after a cycle in which `line_start_i` is high while `pix_o` is not 0. Otherwise it is low, including after a pulse that coincides with `pix_o` = 0.
- R9: `std_o` shows the active standard (0 = 525-line, 1 = 625-line). `std_sel_i` is loaded only at a frame boundary or on a clear, and a change at any other time has no effect on `std_o`, `pix_o` or `line_o`.
- R10: One cycle after `clear_i` is high, `pix_o`, `line_o`, `field_o` and `mismatch_o` are 0, any pending trigger is dropped, and `std_o` equals `std_sel_i`.
- R11: While `rst_ni` is low, `pix_o`, `line_o`, `field_o`, `mismatch_o`, `hsync_o` and `vsync_o` are 0, and `std_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of the counters |
| std_sel_i | input | 1 | Requested standard, 0 = 525-line, 1 = 625-line |
| line_start_i | input | 1 | Upstream line-start pulse |
| vtrig_i | input | 1 | Upstream vertical trigger pulse |
| pix_o | output | PIX_W | Pixel counter within the line |
| line_o | output | LINE_W | Line counter within the frame |
| field_o | output | 1 | Interlace field |
| std_o | output | 1 | Active standard |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync, half-line shifted in field 1 |
| mismatch_o | output | 1 | Upstream line start off the internal line boundary |

## Verification
A wrong pixel wrap or a wrong standard selection shows on `pix_o` within one line: at most 864 cycles, long before the sync outputs could drift far enough to show it. A lost or stale pending trigger, or a wrong line cap, only becomes visible when the next frame boundary moves, so the bench times every frame through the edges of `field_o` and compares the counts against H_TOTAL*lines. A standard switch in the middle of a frame and a trigger in the final cycle of a frame both leave their traces one frame later, so the stimulus runs at least one full frame past each of them.

// File: rtl/tv_sync_pkg.sv
package tv_sync_pkg;
  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } tv_std_e;
endpackage

// File: rtl/tv_sync_hcount.sv
module tv_sync_hcount
  import tv_sync_pkg::*;
#(
  parameter int H_A  = 858,
  parameter int H_B  = 864,
  parameter int HS_SA = 734,
  parameter int HS_EA = 798,
  parameter int HS_SB = 740,
  parameter int HS_EB = 804,
  parameter int PW   = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  tv_std_e       std_i,
  output logic [PW-1:0] pix_o,
  output logic          line_end_o,
  output logic          hsync_o
);
  logic [PW-1:0] pix_q, h_last, hs_s, hs_e;

  always_comb begin
    h_last = (std_i == STD_625) ? PW'(H_B - 1) : PW'(H_A - 1);
    hs_s   = (std_i == STD_625) ? PW'(HS_SB) : PW'(HS_SA);
    hs_e   = (std_i == STD_625) ? PW'(HS_EB) : PW'(HS_EA);
  end

  assign line_end_o = (pix_q == h_last);
  assign hsync_o    = (pix_q >= hs_s) && (pix_q < hs_e);
  assign pix_o      = pix_q;

  // free-running: upstream line timing never touches this counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pix_q <= '0;
    else if (clear_i)    pix_q <= '0;
    else if (line_end_o) pix_q <= '0;
    else                 pix_q <= pix_q + 1'b1;
  end

  AST_PIX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_q <= h_last); // R1
  AST_PIX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_o && !clear_i) |=> (pix_q == '0)); // R2
  AST_HSYNC_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> (pix_q == hs_s)); // R5
endmodule

// File: rtl/tv_sync_vcount.sv
module tv_sync_vcount
  import tv_sync_pkg::*;
#(
  parameter int H_A   = 858,
  parameter int H_B   = 864,
  parameter int CAP_A = 525,
  parameter int CAP_B = 625,
  parameter int VS_SA = 487,
  parameter int VS_EA = 493,
  parameter int VS_SB = 581,
  parameter int VS_EB = 586,
  parameter int PW    = 10,
  parameter int LW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          std_sel_i,
  input  logic          vtrig_i,
  input  logic          line_end_i,
  input  logic [PW-1:0] pix_i,
  output tv_std_e       std_o,
  output logic [LW-1:0] line_o,
  output logic          field_o,
  output logic          vsync_o
);
  tv_std_e       std_q;
  logic [LW-1:0] line_q, cap_last, vs_s, vs_e;
  logic [PW-1:0] half;
  logic          field_q, pend_q, frame_end;

  always_comb begin
    cap_last = (std_q == STD_625) ? LW'(CAP_B - 1) : LW'(CAP_A - 1);
    vs_s     = (std_q == STD_625) ? LW'(VS_SB) : LW'(VS_SA);
    vs_e     = (std_q == STD_625) ? LW'(VS_EB) : LW'(VS_EA);
    half     = (std_q == STD_625) ? PW'(H_B / 2) : PW'(H_A / 2);
  end

  // trigger seen this frame, or cap reached: close the frame at line end
  assign frame_end = line_end_i && (pend_q || vtrig_i || (line_q == cap_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      field_q <= 1'b0;
      std_q   <= STD_525;
      pend_q  <= 1'b0;
    end else if (clear_i) begin
      line_q  <= '0;
      field_q <= 1'b0;
      std_q   <= tv_std_e'(std_sel_i);
      pend_q  <= 1'b0;
    end else if (frame_end) begin
      line_q  <= '0;
      field_q <= ~field_q;
      std_q   <= tv_std_e'(std_sel_i);
      pend_q  <= 1'b0;
    end else begin
      if (line_end_i) line_q <= line_q + 1'b1;
      pend_q <= pend_q | vtrig_i;
    end
  end

  always_comb begin
    if (!field_q)
      vsync_o = (line_q >= vs_s) && (line_q < vs_e);
    else
      vsync_o = ((line_q == vs_s) && (pix_i >= half)) ||
                ((line_q > vs_s) && (line_q < vs_e)) ||
                ((line_q == vs_e) && (pix_i < half));
  end

  assign std_o   = std_q;
  assign line_o  = line_q;
  assign field_o = field_q;

  AST_LINE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= cap_last); // R3
  AST_TRIG_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && line_end_i && !clear_i) |=> (line_q == '0)); // R4
  AST_FIELD_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && !clear_i) |=> (field_q != $past(field_q))); // R7
  AST_STD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_end && !clear_i) |=> $stable(std_q)); // R9
endmodule

// File: rtl/tv_sync_line_check.sv
module tv_sync_line_check #(
  parameter int PW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          line_start_i,
  input  logic [PW-1:0] pix_i,
  output logic          mismatch_o
);
  logic mis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mis_q <= 1'b0;
    else if (clear_i) mis_q <= 1'b0;
    else              mis_q <= line_start_i && (pix_i != '0);
  end

  assign mismatch_o = mis_q;

  AST_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && (pix_i != '0) && !clear_i) |=> mismatch_o); // R8
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && (pix_i == '0)) |=> !mismatch_o); // R8
endmodule

// File: rtl/tv_sync_gen.sv
module tv_sync_gen
  import tv_sync_pkg::*;
#(
  parameter int H_TOTAL_525  = 858,
  parameter int H_TOTAL_625  = 864,
  parameter int HS_START_525 = 734,
  parameter int HS_END_525   = 798,
  parameter int HS_START_625 = 740,
  parameter int HS_END_625   = 804,
  parameter int V_CAP_525    = 525,
  parameter int V_CAP_625    = 625,
  parameter int VS_START_525 = 487,
  parameter int VS_END_525   = 493,
  parameter int VS_START_625 = 581,
  parameter int VS_END_625   = 586,
  localparam int H_MAX  = (H_TOTAL_625 > H_TOTAL_525) ? H_TOTAL_625 : H_TOTAL_525,
  localparam int V_MAX  = (V_CAP_625 > V_CAP_525) ? V_CAP_625 : V_CAP_525,
  localparam int PIX_W  = $clog2(H_MAX),
  localparam int LINE_W = $clog2(V_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              std_sel_i,
  input  logic              line_start_i,
  input  logic              vtrig_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              std_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              mismatch_o
);
  tv_std_e          std_act;
  logic             line_end;
  logic [PIX_W-1:0] pix;

  tv_sync_hcount #(
    .H_A(H_TOTAL_525), .H_B(H_TOTAL_625),
    .HS_SA(HS_START_525), .HS_EA(HS_END_525),
    .HS_SB(HS_START_625), .HS_EB(HS_END_625),
    .PW(PIX_W)
  ) i_hcount (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .std_i(std_act),
    .pix_o(pix), .line_end_o(line_end), .hsync_o(hsync_o)
  );

  tv_sync_vcount #(
    .H_A(H_TOTAL_525), .H_B(H_TOTAL_625),
    .CAP_A(V_CAP_525), .CAP_B(V_CAP_625),
    .VS_SA(VS_START_525), .VS_EA(VS_END_525),
    .VS_SB(VS_START_625), .VS_EB(VS_END_625),
    .PW(PIX_W), .LW(LINE_W)
  ) i_vcount (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .std_sel_i(std_sel_i),
    .vtrig_i(vtrig_i), .line_end_i(line_end), .pix_i(pix),
    .std_o(std_act), .line_o(line_o), .field_o(field_o), .vsync_o(vsync_o)
  );

  tv_sync_line_check #(.PW(PIX_W)) i_line_check (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .line_start_i(line_start_i), .pix_i(pix), .mismatch_o(mismatch_o)
  );

  assign pix_o = pix;
  assign std_o = std_act;
endmodule

// File: tb/test_tv_sync_gen.sv
module test_tv_sync_gen;
  // shortened frame caps keep the run short; line lengths stay real
  localparam int HA = 858, HB = 864;
  localparam int HSA_S = 734, HSA_E = 798, HSB_S = 740, HSB_E = 804;
  localparam int CA = 16, CB = 20;
  localparam int VSA_S = 12, VSA_E = 14, VSB_S = 15, VSB_E = 17;
  localparam int PW = 10, LW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b1, clear_i = 1'b0, std_sel_i = 1'b0;
  logic line_start_i = 1'b0, vtrig_i = 1'b0;
  logic [PW-1:0] pix_o;
  logic [LW-1:0] line_o;
  logic field_o, std_o, hsync_o, vsync_o, mismatch_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  tv_sync_gen #(
    .H_TOTAL_525(HA), .H_TOTAL_625(HB),
    .HS_START_525(HSA_S), .HS_END_525(HSA_E),
    .HS_START_625(HSB_S), .HS_END_625(HSB_E),
    .V_CAP_525(CA), .V_CAP_625(CB),
    .VS_START_525(VSA_S), .VS_END_525(VSA_E),
    .VS_START_625(VSB_S), .VS_END_625(VSB_E)
  ) i_tv_sync_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .std_sel_i(std_sel_i),
    .line_start_i(line_start_i), .vtrig_i(vtrig_i),
    .pix_o(pix_o), .line_o(line_o), .field_o(field_o), .std_o(std_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .mismatch_o(mismatch_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      if (n_fail <= 20) $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model, built from the requirements
  int m_pix, m_line, m_field, m_std, m_pend, m_mis;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pix = 0; m_line = 0; m_field = 0; m_std = 0; m_pend = 0; m_mis = 0;
    end else if (clear_i) begin
      m_pix = 0; m_line = 0; m_field = 0; m_std = int'(std_sel_i); m_pend = 0; m_mis = 0;
    end else begin
      int h, cap;
      bit le;
      h   = m_std ? HB : HA;
      cap = m_std ? CB : CA;
      le  = (m_pix == h - 1);
      m_mis = (line_start_i && m_pix != 0) ? 1 : 0;
      if (le && (m_pend != 0 || vtrig_i || m_line == cap - 1)) begin
        m_line = 0; m_field = 1 - m_field; m_std = int'(std_sel_i); m_pend = 0;
      end else begin
        if (le) m_line++;
        if (vtrig_i) m_pend = 1;
      end
      m_pix = le ? 0 : m_pix + 1;
    end
  end

  function automatic int exp_hs(int p, int s);
    if (s != 0) return (p >= HSB_S && p < HSB_E) ? 1 : 0;
    return (p >= HSA_S && p < HSA_E) ? 1 : 0;
  endfunction

  function automatic int exp_vs(int l, int p, int f, int s);
    int vs, ve, hf;
    vs = s ? VSB_S : VSA_S;
    ve = s ? VSB_E : VSA_E;
    hf = s ? HB / 2 : HA / 2;
    if (f == 0) return (l >= vs && l < ve) ? 1 : 0;
    return ((l == vs && p >= hf) || (l > vs && l < ve) || (l == ve && p < hf)) ? 1 : 0;
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(int'(pix_o) == m_pix, m_std ? "R2 pixel counter" : "R1 pixel counter", int'(pix_o), m_pix);
      check(int'(line_o) == m_line, "R3 R4 line counter", int'(line_o), m_line);
      check(int'(hsync_o) == exp_hs(m_pix, m_std), "R5 hsync", int'(hsync_o), exp_hs(m_pix, m_std));
      check(int'(vsync_o) == exp_vs(m_line, m_pix, m_field, m_std), "R6 vsync", int'(vsync_o),
            exp_vs(m_line, m_pix, m_field, m_std));
      check(int'(field_o) == m_field, "R7 field", int'(field_o), m_field);
      check(int'(mismatch_o) == m_mis, "R8 mismatch", int'(mismatch_o), m_mis);
      check(int'(std_o) == m_std, "R9 active standard", int'(std_o), m_std);
    end
  end

  // count cycles from a frame start to the next field edge; trigger at cycle trig_at
  task automatic measure(input int trig_at, output int n);
    logic f0;
    f0 = field_o;
    n = 0;
    forever begin
      vtrig_i = (n == trig_at);
      @(negedge clk_i);
      n++;
      if (field_o != f0) break;
    end
    vtrig_i = 1'b0;
  endtask

  task automatic do_clear(input logic s);
    std_sel_i = s;
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    check(pix_o == '0 && line_o == '0 && field_o == 1'b0 && mismatch_o == 1'b0,
          "R10 clear state", int'({pix_o, line_o, field_o}), 0);
    check(std_o == s, "R10 clear loads standard", int'(std_o), int'(s));
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    #2 rst_ni = 1'b0;
    #3;
    check(pix_o == '0 && line_o == '0 && field_o == 1'b0, "R11 reset counters",
          int'({pix_o, line_o, field_o}), 0);
    check(hsync_o == 1'b0 && vsync_o == 1'b0 && mismatch_o == 1'b0 && std_o == 1'b0,
          "R11 reset outputs", int'({hsync_o, vsync_o, mismatch_o, std_o}), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // 525-line frame on the cap
    do_clear(1'b0);
    measure(-1, n);
    check(n == HA * CA, "R1 R3 full 525 frame", n, HA * CA);

    // selection change mid-frame, lands at the next boundary
    repeat (500) @(negedge clk_i);
    std_sel_i = 1'b1;
    repeat (200) @(negedge clk_i);
    check(std_o == 1'b0, "R9 std held mid-frame", int'(std_o), 0);
    measure(-1, n);
    check(std_o == 1'b1, "R9 std switched at boundary", int'(std_o), 1);
    measure(-1, n);
    check(n == HB * CB, "R2 R3 full 625 frame", n, HB * CB);

    // early trigger: 625 mode, mid line 3 -> frame of 4 lines
    measure(3 * HB + 100, n);
    check(n == 4 * HB, "R4 early trigger frame", n, 4 * HB);

    // trigger in final cycle is absorbed
    do_clear(1'b0);
    measure(HA * CA - 1, n);
    check(n == HA * CA, "R4 final-cycle trigger frame", n, HA * CA);
    measure(-1, n);
    check(n == HA * CA, "R4 trigger absorbed, next frame full", n, HA * CA);

    // upstream line start off and on the boundary
    while (pix_o != 10'd5) @(negedge clk_i);
    line_start_i = 1'b1;
    @(negedge clk_i);
    line_start_i = 1'b0;
    check(mismatch_o == 1'b1, "R8 off-boundary line start", int'(mismatch_o), 1);
    check(int'(pix_o) == 6, "R1 pixel ignores upstream start", int'(pix_o), 6);
    while (pix_o != '0) @(negedge clk_i);
    line_start_i = 1'b1;
    @(negedge clk_i);
    line_start_i = 1'b0;
    check(mismatch_o == 1'b0, "R8 aligned line start", int'(mismatch_o), 0);

    // random mix
    for (int i = 0; i < 40000; i++) begin
      line_start_i = (pix_o == '0) ? ($urandom_range(3) != 0) : ($urandom_range(400) == 0);
      vtrig_i      = ($urandom_range(4000) == 0);
      if ($urandom_range(6000) == 0) std_sel_i = ~std_sel_i;
      clear_i      = ($urandom_range(25000) == 0);
      @(negedge clk_i);
    end
    line_start_i = 1'b0; vtrig_i = 1'b0; clear_i = 1'b0;
    repeat (10) @(negedge clk_i);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule